// File: doc/BRIEF.md
# One-Time-Programmable Configuration Memory SPI Target

This block is a serial target that behaves like a small one-time-programmable configuration store. A host drives it over a mode-0 SPI link (clock idles low, data sampled on the rising edge, changed on the falling edge, most significant bit first). The target stays silent until the host sends a six-byte unlock key inside one chip-select frame. After that it decodes byte-framed commands: program-latch on and off, a status read, a memory write, a memory read with a fixed block of dummy bytes, bank selection, and a write and read of a volatile 64-bit trim register.

Three banks share one address space: main, trim and signature, each a small on-chip byte array. Writing can only set bits; each stored byte becomes the old value ORed with the new one. Signature byte 0 returns a fixed device identifier. An accepted write keeps the busy bits of the status register high for a set number of system clocks, and during that window every command except the status read is dropped. All SPI inputs are brought into the system-clock domain, so the SPI clock must run well below the system clock.

Top module: `otp_cfg_spi_target`

## Requirements
- R1: Every command is ignored until the bytes 7E AA 99 7E 01 0E arrive as the first six bytes of one chip-select frame. A key split across frames does not unlock the target, and a status read while locked returns 0x00.
- R2: Status (opcode 0x05, reply in the following byte) has bit 1 equal to the program latch and bits 7, 6 and 0 equal to busy, with all other bits 0. Opcode 0x06 sets the latch and opcode 0x04 clears it.
- R3: Opcode 0x03 takes a 3-byte address, most significant byte first, then nine dummy bytes. The target then streams bytes of the selected bank from that address upward for as long as chip select stays low, and the address wraps at the bank depth (256 for main).
- R4: Opcode 0x02 with a 3-byte address and eight data bytes ORs the data into addresses addr to addr+7 of the selected bank, wrapping at the bank depth. Bits already set stay set.
- R5: An 0x02 write sent while the program latch is clear changes nothing and does not start busy.
- R6: Opcode 0x83 with address 0x000025 and data 0x00, 0x10 or 0x20 selects the main, trim or signature bank. Any other data value or address leaves the selection unchanged. After reset the main bank is selected.
- R7: Signature byte 0 always reads the device identifier (0x20 by default), and writes to it are ignored.
- R8: Opcode 0x82 with address 0x000020 and eight data bytes overwrites the 64-bit trim register, whether or not the latch is set. With any other address it does nothing. Opcode 0x84 takes a 3-byte address and nine dummy bytes, then returns the register most significant byte first.
- R9: An applied 0x02 or 0x82 raises busy for BUSY_CYCLES system clocks after chip select rises. While busy, every opcode other than 0x05 is ignored.
- R10: If chip select rises before a write, trim write or bank select is complete (12, 12 and 5 bytes), the command has no effect.
- R11: MISO is low outside a frame and whenever no reply is pending. Reply bits change on falling SCK edges, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | SPI clock from the host, idles low |
| cs_n | input | 1 | Active-low chip select that frames a command |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial reply data to the host |

## Verification
Busy timing and command decode can fall in the same cycle. The busy window that a write commit opens is still running when the host's next frame decodes its opcode. The bench provokes this with a large busy count: it sends a latch-clear command right after an applied write and checks the outcome through status. Status must read 0xC3 during the window and 0x02 after it, which shows the latch clear was dropped. A second collision is bit-level: a reply byte has to be loaded on the same falling edge that would otherwise shift the previous one. The bench checks this by comparing every streamed read byte against a scoreboard of expected values.

// File: rtl/otp_pkg.sv
// Shared opcodes, bank codes and helper functions for the OTP configuration target.
package otp_pkg;

    typedef enum logic [1:0] {
        BANK_MAIN = 2'd0,
        BANK_TRIM = 2'd1,
        BANK_SIG  = 2'd2
    } bank_e;

    localparam logic [7:0] OP_WRITE   = 8'h02;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_PGM_OFF = 8'h04;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_PGM_ON  = 8'h06;
    localparam logic [7:0] OP_TRIM_WR = 8'h82;
    localparam logic [7:0] OP_BANK    = 8'h83;
    localparam logic [7:0] OP_TRIM_RD = 8'h84;

    localparam logic [23:0] BANK_SEL_ADDR = 24'h000025;
    localparam logic [23:0] TRIM_REG_ADDR = 24'h000020;

    // Unlock key byte for a given position within the frame.
    function automatic logic [7:0] key_at(input logic [2:0] pos);
        case (pos)
            3'd0:    key_at = 8'h7E;
            3'd1:    key_at = 8'hAA;
            3'd2:    key_at = 8'h99;
            3'd3:    key_at = 8'h7E;
            3'd4:    key_at = 8'h01;
            3'd5:    key_at = 8'h0E;
            default: key_at = 8'h00;
        endcase
    endfunction

    // True when a bank-select data byte names a real bank.
    function automatic logic bank_code_ok(input logic [7:0] code);
        bank_code_ok = (code == 8'h00) || (code == 8'h10) || (code == 8'h20);
    endfunction

    // Bank named by a valid bank-select data byte.
    function automatic bank_e bank_of_code(input logic [7:0] code);
        case (code)
            8'h10:   bank_of_code = BANK_TRIM;
            8'h20:   bank_of_code = BANK_SIG;
            default: bank_of_code = BANK_MAIN;
        endcase
    endfunction

endpackage

// File: rtl/otp_spi_phy.sv
// SPI mode-0 byte shifter.
// Brings sck, cs_n and mosi into the clk domain and assembles received bytes.
// Shifts reply bytes out on falling SCK edges.
// Assumes SCK is at least four times slower than clk.
// A byte queued with tx_load goes onto MISO at the next falling edge.
module otp_spi_phy (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    output logic       frame_active,
    output logic       frame_end,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    input  logic       tx_load,
    input  logic [7:0] tx_byte
);

    logic [2:0] sck_sr;
    logic [2:0] cs_sr;
    logic [1:0] mosi_sr;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       pend_q;
    logic [7:0] pend_byte;
    logic       sck_rise;
    logic       sck_fall;

    assign frame_active = !cs_sr[1];
    assign frame_end    = cs_sr[1] && !cs_sr[2];
    assign sck_rise     = sck_sr[1] && !sck_sr[2];
    assign sck_fall     = !sck_sr[1] && sck_sr[2];
    assign miso         = tx_sr[7];

    // Two-stage synchronisers plus one edge-detect stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sr  <= 3'b000;
            cs_sr   <= 3'b111;
            mosi_sr <= 2'b00;
        end else begin
            sck_sr  <= {sck_sr[1:0], sck};
            cs_sr   <= {cs_sr[1:0], cs_n};
            mosi_sr <= {mosi_sr[0], mosi};
        end
    end

    // Receive: sample MOSI on rising SCK and flag each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= 3'd0;
            rx_sr    <= 7'd0;
            rx_valid <= 1'b0;
            rx_byte  <= 8'd0;
        end else begin
            rx_valid <= 1'b0;
            if (!frame_active) begin
                bit_cnt <= 3'd0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx_sr   <= {rx_sr[5:0], mosi_sr[1]};
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sr, mosi_sr[1]};
                end
            end
        end
    end

    // Transmit: load a pending byte or shift on falling SCK; clear outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr     <= 8'd0;
            pend_q    <= 1'b0;
            pend_byte <= 8'd0;
        end else if (!frame_active) begin
            tx_sr  <= 8'd0;
            pend_q <= 1'b0;
        end else begin
            if (tx_load) begin
                pend_q    <= 1'b1;
                pend_byte <= tx_byte;
            end
            if (sck_fall) begin
                if (pend_q) begin
                    tx_sr  <= pend_byte;
                    pend_q <= 1'b0;
                end else begin
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    // R11: MISO is released to low one clock after the frame closes.
    p_miso_idle_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        !frame_active |=> !miso);

    // R10: bytes are only assembled inside a frame.
    p_rx_in_frame_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(frame_active));

endmodule

// File: rtl/otp_byte_array.sv
// One OTP bank: DEPTH bytes that only accept set bits.
// A write ORs eight bytes into base..base+7, wrapping at DEPTH.
// Optionally byte 0 is a fixed read-only value.
// Assumes DEPTH is a power of two and at least 16.
module otp_byte_array #(
    parameter int         DEPTH     = 256,
    parameter bit         HAS_FIXED = 1'b0,
    parameter logic [7:0] FIXED_VAL = 8'h00,
    localparam int        AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_base,
    input  logic [63:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] slot  [8];

    for (genvar k = 0; k < 8; k++) begin : g_slot
        assign slot[k] = wr_base + AW'(k);
    end

    // Clear to blank on reset; OR eight bytes in on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (wr_en) begin
            for (int k = 0; k < 8; k++) begin
                if (!(HAS_FIXED && slot[k] == '0))
                    mem_q[slot[k]] <= mem_q[slot[k]] | wr_data[8*(7-k) +: 8];
            end
        end
    end

    assign rd_data = (HAS_FIXED && rd_addr == '0) ? FIXED_VAL : mem_q[rd_addr];

    // R4: a byte watched at a steady address never loses a set bit.
    p_sticky_bits_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == $past(rd_addr)) |-> (($past(rd_data) & ~rd_data) == 8'h00));

endmodule

// File: rtl/otp_cmd_engine.sv
// Command decoder for the OTP target.
// Holds the unlock state, program latch, busy counter, bank selection and trim register.
// Counts the bytes of a frame and queues reply bytes.
// It decides at chip-select rise whether a write, trim write or bank select is applied.
// Assumes no new byte arrives within two clocks of frame_end.
module otp_cmd_engine
    import otp_pkg::*;
#(
    parameter int  BUSY_CYCLES = 64,
    parameter int  PW          = 8,
    localparam int BW          = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_active,
    input  logic          frame_end,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic [7:0]    rd_byte,
    output logic          tx_load,
    output logic [7:0]    tx_byte,
    output logic          wr_en,
    output logic [PW-1:0] wr_base,
    output logic [63:0]   wr_data,
    output logic [PW-1:0] rd_ptr,
    output bank_e         bank
);

    logic          unlocked_q;
    logic          key_ok_q;
    logic          cmd_ok_q;
    logic          wel_q;
    logic [BW-1:0] busy_q;
    logic [4:0]    cnt_q;
    logic [7:0]    op_q;
    logic [23:0]   addr_q;
    logic [63:0]   data_q;
    logic [63:0]   trim_q;
    logic [PW-1:0] ptr_q;
    logic [2:0]    tidx_q;
    logic          busy;
    logic [7:0]    status;
    logic [23:0]   addr_next;
    logic          commit_wr;
    logic          commit_trim;
    logic          commit_bank;

    assign busy      = (busy_q != '0);
    assign status    = {busy, busy, 4'b0000, wel_q, busy};
    assign addr_next = {addr_q[15:0], rx_byte};
    assign wr_base   = addr_q[PW-1:0];
    assign wr_data   = data_q;
    assign rd_ptr    = ptr_q;

    // Decide which frame-level command takes effect at chip-select rise.
    always_comb begin
        commit_wr   = frame_end && cmd_ok_q && (op_q == OP_WRITE) && (cnt_q == 5'd12) && wel_q;
        commit_trim = frame_end && cmd_ok_q && (op_q == OP_TRIM_WR) && (cnt_q == 5'd12)
                      && (addr_q == TRIM_REG_ADDR);
        commit_bank = frame_end && cmd_ok_q && (op_q == OP_BANK) && (cnt_q == 5'd5)
                      && (addr_q == BANK_SEL_ADDR) && bank_code_ok(data_q[7:0]);
    end

    // Byte decode: key match, opcode, address, data, latch and reply queueing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
            key_ok_q   <= 1'b1;
            cmd_ok_q   <= 1'b0;
            wel_q      <= 1'b0;
            cnt_q      <= 5'd0;
            op_q       <= 8'h00;
            addr_q     <= 24'h0;
            data_q     <= 64'h0;
            ptr_q      <= '0;
            tidx_q     <= 3'd0;
            tx_load    <= 1'b0;
            tx_byte    <= 8'h00;
        end else begin
            tx_load <= 1'b0;
            if (!frame_active) begin
                cnt_q    <= 5'd0;
                key_ok_q <= 1'b1;
                cmd_ok_q <= 1'b0;
            end else if (rx_valid) begin
                if (cnt_q != 5'd31) cnt_q <= cnt_q + 5'd1;
                if (!unlocked_q) begin
                    if (key_ok_q && cnt_q < 5'd6 && rx_byte == key_at(cnt_q[2:0])) begin
                        if (cnt_q == 5'd5) unlocked_q <= 1'b1;
                    end else begin
                        key_ok_q <= 1'b0;
                    end
                end
                if (cnt_q == 5'd0) begin
                    op_q     <= rx_byte;
                    cmd_ok_q <= unlocked_q && (!busy || rx_byte == OP_STATUS);
                    if (unlocked_q && !busy && rx_byte == OP_PGM_ON)  wel_q <= 1'b1;
                    if (unlocked_q && !busy && rx_byte == OP_PGM_OFF) wel_q <= 1'b0;
                    if (unlocked_q && rx_byte == OP_STATUS) begin
                        tx_load <= 1'b1;
                        tx_byte <= status;
                    end
                end else if (cnt_q < 5'd4) begin
                    addr_q <= addr_next;
                    if (cnt_q == 5'd3) begin
                        ptr_q  <= addr_next[PW-1:0];
                        tidx_q <= 3'd0;
                    end
                end else if (cnt_q < 5'd12) begin
                    data_q <= {data_q[55:0], rx_byte};
                end
                if (cnt_q >= 5'd12 && cmd_ok_q) begin
                    if (op_q == OP_READ) begin
                        tx_load <= 1'b1;
                        tx_byte <= rd_byte;
                        ptr_q   <= ptr_q + 1'b1;
                    end else if (op_q == OP_TRIM_RD) begin
                        tx_load <= 1'b1;
                        tx_byte <= trim_q[{~tidx_q, 3'b000} +: 8];
                        tidx_q  <= tidx_q + 3'd1;
                    end
                end
            end
        end
    end

    // Frame-level effects: write strobe, busy window, trim register and bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en  <= 1'b0;
            busy_q <= '0;
            trim_q <= 64'h0;
            bank   <= BANK_MAIN;
        end else begin
            wr_en <= commit_wr;
            if (commit_wr || commit_trim) busy_q <= BW'(BUSY_CYCLES);
            else if (busy)                busy_q <= busy_q - 1'b1;
            if (commit_trim) trim_q <= data_q;
            if (commit_bank) bank   <= bank_of_code(data_q[7:0]);
        end
    end

    // R1: while locked nothing replies, writes or sets the latch.
    p_locked_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked_q |-> (!wel_q && !tx_load && !wr_en));

    // R9: busy only opens right after a frame closes.
    p_busy_from_commit_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(frame_end));

    // R9: latch opcodes arriving while busy leave the latch alone.
    p_busy_freeze_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_valid && frame_active && cnt_q == 5'd0 && rx_byte != OP_STATUS)
        |=> $stable(wel_q));

    // R10: a frame that closes without exactly twelve bytes never writes.
    p_abort_no_write_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cnt_q != 5'd12) |=> !wr_en);

    // R5: a write strobe only occurs with the program latch set.
    p_write_needs_latch_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wel_q);

endmodule

// File: rtl/otp_cfg_spi_target.sv
// Top level of the OTP configuration memory SPI target.
// Joins the SPI shifter and the command engine with the three bank arrays
// (main, trim, signature). Only the selected bank is written, and only the
// selected bank feeds the read stream.
module otp_cfg_spi_target
    import otp_pkg::*;
#(
    parameter int         MAIN_DEPTH  = 256,
    parameter int         TRIM_DEPTH  = 256,
    parameter int         SIG_DEPTH   = 16,
    parameter logic [7:0] DEVICE_ID   = 8'h20,
    parameter int         BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);

    localparam int MAX_DEPTH = (MAIN_DEPTH > TRIM_DEPTH)
                             ? ((MAIN_DEPTH > SIG_DEPTH) ? MAIN_DEPTH : SIG_DEPTH)
                             : ((TRIM_DEPTH > SIG_DEPTH) ? TRIM_DEPTH : SIG_DEPTH);
    localparam int PW = $clog2(MAX_DEPTH);

    logic          frame_active;
    logic          frame_end;
    logic          rx_valid;
    logic [7:0]    rx_byte;
    logic          tx_load;
    logic [7:0]    tx_byte;
    logic          wr_en;
    logic [PW-1:0] wr_base;
    logic [63:0]   wr_data;
    logic [PW-1:0] rd_ptr;
    bank_e         bank;
    logic [7:0]    rd_byte;
    logic [7:0]    bank_rd [3];
    logic [2:0]    bank_we;

    otp_spi_phy i_phy (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck          (sck),
        .cs_n         (cs_n),
        .mosi         (mosi),
        .miso         (miso),
        .frame_active (frame_active),
        .frame_end    (frame_end),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .tx_load      (tx_load),
        .tx_byte      (tx_byte)
    );

    otp_cmd_engine #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .PW          (PW)
    ) i_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_active (frame_active),
        .frame_end    (frame_end),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rd_byte      (rd_byte),
        .tx_load      (tx_load),
        .tx_byte      (tx_byte),
        .wr_en        (wr_en),
        .wr_base      (wr_base),
        .wr_data      (wr_data),
        .rd_ptr       (rd_ptr),
        .bank         (bank)
    );

    for (genvar b = 0; b < 3; b++) begin : g_bank
        localparam int DEP = (b == 0) ? MAIN_DEPTH : ((b == 1) ? TRIM_DEPTH : SIG_DEPTH);
        localparam int AWB = $clog2(DEP);

        assign bank_we[b] = wr_en && (bank == bank_e'(b));

        otp_byte_array #(
            .DEPTH     (DEP),
            .HAS_FIXED (b == 2),
            .FIXED_VAL (DEVICE_ID)
        ) i_array (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_we[b]),
            .wr_base (wr_base[AWB-1:0]),
            .wr_data (wr_data),
            .rd_addr (rd_ptr[AWB-1:0]),
            .rd_data (bank_rd[b])
        );
    end

    // Route the selected bank to the read stream.
    always_comb begin
        case (bank)
            BANK_MAIN: rd_byte = bank_rd[0];
            BANK_TRIM: rd_byte = bank_rd[1];
            BANK_SIG:  rd_byte = bank_rd[2];
            default:   rd_byte = 8'h00;
        endcase
    end

    // R6: at most one bank receives a write strobe.
    p_one_bank_written_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

endmodule

// File: tb/test_otp_cfg_spi_target.sv
// Scoreboard bench: driver tasks queue expected reply bytes, a monitor pops and compares.
module test_otp_cfg_spi_target;

    localparam int HALF = 8;
    localparam int BUSY = 1000;

    logic clk = 1'b0;
    logic rst_n;
    logic sck;
    logic cs_n;
    logic mosi;
    logic miso;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_q [$];
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #10 clk = ~clk;

    otp_cfg_spi_target #(.BUSY_CYCLES(BUSY)) i_otp_cfg_spi_target (
        .clk   (clk),
        .rst_n (rst_n),
        .sck   (sck),
        .cs_n  (cs_n),
        .mosi  (mosi),
        .miso  (miso)
    );

    // Monitor: compare each received reply byte with the next expected one.
    always @(posedge clk) begin
        if (got_q.size() > 0) begin
            logic [7:0] g;
            logic [7:0] e;
            string      t;
            g = got_q.pop_front();
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected reply: actual %02h expected none", g);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (g !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, g, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic chk(input logic act, input logic expv, input string t);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", t, act, expv);
        end
    endtask

    task automatic expect_b(input logic [7:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xb(input logic [7:0] b);
        logic [7:0] r;
        spi_byte(b, r);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_lo(); xb(op); cs_hi();
    endtask

    task automatic status_rd();
        logic [7:0] r;
        cs_lo(); xb(8'h05); spi_byte(8'h00, r); got_q.push_back(r); cs_hi();
    endtask

    task automatic send_addr(input logic [23:0] a);
        xb(a[23:16]); xb(a[15:8]); xb(a[7:0]);
    endtask

    task automatic write8(input logic [7:0] op, input logic [23:0] a, input logic [63:0] d);
        cs_lo(); xb(op); send_addr(a);
        for (int i = 7; i >= 0; i--) xb(d[8*i +: 8]);
        cs_hi();
    endtask

    task automatic read_n(input logic [7:0] op, input logic [23:0] a, input int n);
        logic [7:0] r;
        cs_lo(); xb(op); send_addr(a);
        for (int i = 0; i < 9; i++) xb(8'h00);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, r);
            got_q.push_back(r);
        end
        cs_hi();
    endtask

    task automatic bank_sel(input logic [23:0] a, input logic [7:0] code);
        cs_lo(); xb(8'h83); send_addr(a); xb(code); cs_hi();
    endtask

    task automatic unlock();
        cs_lo();
        xb(8'h7E); xb(8'hAA); xb(8'h99); xb(8'h7E); xb(8'h01); xb(8'h0E);
        cs_hi();
    endtask

    task automatic wait_idle();
        repeat (BUSY + 100) @(negedge clk);
    endtask

    task automatic expect_row(input logic [63:0] v, input int n, input string t);
        for (int i = 0; i < n; i++) expect_b(v[8*(7-i) +: 8], t);
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(miso, 1'b0, "R11 reset idle miso");

        // R1: locked target ignores the latch command and answers status with zero.
        cmd1(8'h06);
        expect_b(8'h00, "R1 status while locked"); status_rd();
        cs_lo(); xb(8'h7E); xb(8'hAA); xb(8'h99); cs_hi();
        cs_lo(); xb(8'h7E); xb(8'h01); xb(8'h0E); cs_hi();
        cmd1(8'h06);
        unlock();
        expect_b(8'h00, "R1 split key must not unlock"); status_rd();

        // R2: latch on and off as seen in status.
        cmd1(8'h06);
        expect_b(8'h02, "R2 latch set"); status_rd();
        cmd1(8'h04);
        expect_b(8'h00, "R2 latch clear"); status_rd();

        // R5: write with latch clear is dropped and starts no busy window.
        write8(8'h02, 24'h000010, 64'h1122334455667788);
        expect_b(8'h00, "R5 no busy without latch"); status_rd();
        expect_row(64'h0, 2, "R5 memory unchanged"); read_n(8'h03, 24'h000010, 2);

        // R9: write, then status and a latch clear inside the busy window.
        cmd1(8'h06);
        write8(8'h02, 24'h000010, 64'h1122334455667788);
        expect_b(8'hC3, "R9 busy after write"); status_rd();
        cmd1(8'h04);
        wait_idle();
        expect_b(8'h02, "R9 latch clear ignored while busy"); status_rd();

        // R3 and R4: stream across the written row with blanks around it.
        expect_b(8'h00, "R3 blank before"); expect_b(8'h00, "R3 blank before");
        expect_row(64'h1122334455667788, 8, "R4 written row");
        expect_b(8'h00, "R3 blank after"); expect_b(8'h00, "R3 blank after");
        read_n(8'h03, 24'h00000E, 12);

        // R4: second write only adds bits.
        write8(8'h02, 24'h000010, 64'hF00F000000000001);
        wait_idle();
        expect_row(64'hF12F334455667789, 8, "R4 OR merge"); read_n(8'h03, 24'h000010, 8);

        // R3 and R4: write and read both wrap at the bank end.
        write8(8'h02, 24'h0000FE, 64'hAABBCCDDEE010203);
        wait_idle();
        expect_row(64'hAABBCCDD00000000, 4, "R3 wrap at bank end");
        read_n(8'h03, 24'h0000FE, 4);

        // R10: truncated write and truncated bank select have no effect.
        cs_lo(); xb(8'h02); send_addr(24'h000040);
        for (int i = 0; i < 5; i++) xb(8'hFF);
        cs_hi();
        expect_b(8'h02, "R10 aborted write not busy"); status_rd();
        expect_row(64'h0, 8, "R10 aborted write no data"); read_n(8'h03, 24'h000040, 8);
        cs_lo(); xb(8'h83); send_addr(24'h000025); cs_hi();
        expect_b(8'hF1, "R10 aborted bank select"); read_n(8'h03, 24'h000010, 1);

        // R6: trim bank selection, invalid codes and wrong address.
        bank_sel(24'h000025, 8'h10);
        write8(8'h02, 24'h000060, 64'h0015F2F1C4000000);
        wait_idle();
        expect_row(64'h0015F2F1C4000000, 8, "R6 trim bank row"); read_n(8'h03, 24'h000060, 8);
        bank_sel(24'h000025, 8'h30);
        expect_b(8'h15, "R6 invalid code ignored"); read_n(8'h03, 24'h000061, 1);
        bank_sel(24'h000026, 8'h00);
        expect_b(8'h15, "R6 wrong address ignored"); read_n(8'h03, 24'h000061, 1);
        bank_sel(24'h000025, 8'h00);
        expect_b(8'h00, "R6 main bank at 0x60"); expect_b(8'h00, "R6 main bank at 0x61");
        read_n(8'h03, 24'h000060, 2);

        // R7: signature identifier is fixed; neighbours accept writes.
        bank_sel(24'h000025, 8'h20);
        expect_b(8'h20, "R7 device id"); expect_b(8'h00, "R7 sig byte 1 blank");
        read_n(8'h03, 24'h000000, 2);
        write8(8'h02, 24'h000000, 64'hFF5A000000000000);
        wait_idle();
        expect_b(8'h20, "R7 id read-only"); expect_b(8'h5A, "R7 sig byte 1 written");
        read_n(8'h03, 24'h000000, 2);

        // R8: trim register overwrite and read-back.
        cmd1(8'h04);
        write8(8'h82, 24'h000020, 64'h00000000C4000000);
        wait_idle();
        expect_row(64'h00000000C4000000, 8, "R8 trim register read");
        read_n(8'h84, 24'h000020, 8);
        write8(8'h82, 24'h000020, 64'h0015F2F0C2000000);
        wait_idle();
        expect_row(64'h0015F2F0C2000000, 8, "R8 trim register overwrite");
        read_n(8'h84, 24'h000020, 8);
        write8(8'h82, 24'h000028, 64'hFFFFFFFFFFFFFFFF);
        expect_b(8'h00, "R8 wrong address not busy"); status_rd();
        expect_row(64'h0015F2F0C2000000, 8, "R8 wrong address ignored");
        read_n(8'h84, 24'h000020, 8);

        chk(miso, 1'b0, "R11 idle miso after frames");

        repeat (20) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual %0d leftover expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule